// File: doc/BRIEF.md
# Three-Identity I2C Target Front End

This block is the serial front end of a combined memory and temperature-sensing device. It watches an I2C bus that is oversampled by a much faster system clock. It answers three different 4-bit type codes, and each code is joined with three strap pins to form a full 7-bit bus address. Each accepted transaction is steered to one of three back ends: a byte-wide memory port, a port for write-protection commands, or a 16-bit register file. The register file is reached only through an internal pointer byte.

The block never holds SCL low, so it cannot stretch the clock. It drives SDA only through an open-drain enable, both to acknowledge bytes and to send read data. Each back end sees single-cycle request strobes. Read data must be valid from the cycle after the read strobe and must stay stable until the next SCL falling edge. Register data moves as two bytes, high byte first. A register write reaches the register file only after its second byte has been acknowledged.

Top module: `tri_id_i2c_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a fresh address phase from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the block to idle. After reset and after either condition, sda_oe_o is low.
- R2: The address byte is shifted in MSB first. Bits 7..4 hold the type code, bits 3..1 must equal strap_i[2:0], and bit 0 selects the direction (1 = read, 0 = write). The byte is acknowledged only when the type code is 1010, 0110 or 0011 and the strap bits match.
- R3: An address byte that fails R2 is not acknowledged. After it, the block drives no SDA low and raises no strobe until the next START.
- R4: In a matched transaction, the block pulls SDA low for the whole ninth SCL period after every byte it receives. Outside those periods it drives SDA low only for the zero bits of a byte it is sending.
- R5: On a write with code 1010, each data byte produces one mem_wr_o pulse once its acknowledge period ends, with the byte on byte_wdata_o. mem_first_o is high only for the first data byte after the address.
- R6: On a read with code 1010, mem_rd_o pulses when the address is acknowledged and again each time the master acknowledges a byte. The byte on mem_rdata_i is sent MSB first. A master NoAck ends the transfer with no further strobe.
- R7: Code 0110 behaves as R5 and R6 do, but uses prot_wr_o, prot_rd_o and prot_rdata_i, and has no first-byte flag.
- R8: On a write with code 0011, the first data byte loads the pointer shown on reg_ptr_o. Each following pair of bytes, high byte first, produces one reg_wr_o pulse carrying reg_wdata_o after the second byte's acknowledge. Further pairs reuse the same pointer.
- R9: A register pair cut short by a STOP or START before its second byte is acknowledged produces no reg_wr_o.
- R10: On a read with code 0011, reg_rd_o pulses with the current pointer when the address is acknowledged. The word on reg_rdata_i is then sent high byte first, and the strobe repeats for every further pair. The pointer keeps its value across STOP and repeated START.
- R11: At most one request strobe is high in any cycle, and each strobe is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Strap pins forming address bits 3..1 |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| byte_wdata_o | output | 8 | Write byte for the memory and protection ports |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_first_o | output | 1 | Marks the first data byte after the address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read byte |
| prot_wr_o | output | 1 | Protection command write strobe |
| prot_rd_o | output | 1 | Protection status read strobe |
| prot_rdata_i | input | 8 | Protection status byte |
| reg_ptr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 16 | Register write word |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 16 | Register read word |

## Verification
A wrong state in the bit counter or the protocol state machine shows up within one byte time. The acknowledge appears in the wrong SCL period, or the strobe carries the wrong byte, and the bench samples both at every ninth clock. A corrupted pointer or register-pair index stays hidden until the next register access. So every pointer write is followed by a strobe check on the pointer, and by a readback, including one that follows a STOP after an interrupted pair. Strobes are compared in every system clock against an ordered list of expected requests, so a stray or missing pulse is reported in the cycle it occurs.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_MEM  = 2'd1,
      TGT_PROT = 2'd2,
      TGT_SENS = 2'd3
   } tgt_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK
   } st_e;

   localparam int NUM_CODES = 3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RESET_VAL}};
         prev  <= RESET_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_tgt_pkg::*;
#(
   parameter int                CODE_W    = 4,
   parameter int                STRAP_W   = 3,
   parameter logic [CODE_W-1:0] CODE_MEM  = 4'b1010,
   parameter logic [CODE_W-1:0] CODE_PROT = 4'b0110,
   parameter logic [CODE_W-1:0] CODE_SENS = 4'b0011
) (
   input  logic [CODE_W+STRAP_W-1:0] addr_i,
   input  logic [STRAP_W-1:0]        strap_i,
   output logic                      hit_o,
   output tgt_e                      tgt_o
);
   localparam int ADDR_W = CODE_W + STRAP_W;
   localparam logic [NUM_CODES*CODE_W-1:0] CODES = {CODE_SENS, CODE_PROT, CODE_MEM};

   if (CODE_MEM == CODE_PROT || CODE_MEM == CODE_SENS || CODE_PROT == CODE_SENS) begin : g_bad_codes
      $error("i2c_addr_match: type codes must differ");
   end

   logic [NUM_CODES-1:0] code_hit;
   logic                 strap_ok;

   for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_code
      assign code_hit[gi] = (addr_i[ADDR_W-1 -: CODE_W] == CODES[gi*CODE_W +: CODE_W]);
   end

   assign strap_ok = (addr_i[STRAP_W-1:0] == strap_i);

   always_comb begin
      tgt_o = TGT_NONE;
      if (strap_ok) begin
         if (code_hit[0])      tgt_o = TGT_MEM;
         else if (code_hit[1]) tgt_o = TGT_PROT;
         else if (code_hit[2]) tgt_o = TGT_SENS;
      end
   end

   assign hit_o = (tgt_o != TGT_NONE);
endmodule

// File: rtl/tri_id_i2c_target.sv
module tri_id_i2c_target
   import i2c_tgt_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                CODE_W      = 4,
   parameter int                STRAP_W     = 3,
   parameter int                DATA_W      = 8,
   parameter int                REG_W       = 16,
   parameter int                PTR_W       = 8,
   parameter logic [CODE_W-1:0] CODE_MEM    = 4'b1010,
   parameter logic [CODE_W-1:0] CODE_PROT   = 4'b0110,
   parameter logic [CODE_W-1:0] CODE_SENS   = 4'b0011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_oe_o,
   output logic [DATA_W-1:0]  byte_wdata_o,
   output logic               mem_wr_o,
   output logic               mem_first_o,
   output logic               mem_rd_o,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic               prot_wr_o,
   output logic               prot_rd_o,
   input  logic [DATA_W-1:0]  prot_rdata_i,
   output logic [PTR_W-1:0]   reg_ptr_o,
   output logic [REG_W-1:0]   reg_wdata_o,
   output logic               reg_wr_o,
   output logic               reg_rd_o,
   input  logic [REG_W-1:0]   reg_rdata_i
);
   localparam int REG_BYTES = REG_W / DATA_W;
   localparam int RB_W      = (REG_BYTES > 2) ? $clog2(REG_BYTES) : 1;
   localparam int BIT_W     = $clog2(DATA_W + 1);
   localparam logic [RB_W-1:0]  RB_LAST  = RB_W'(REG_BYTES - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W);

   if (CODE_W + STRAP_W + 1 != DATA_W) begin : g_bad_addr
      $error("tri_id_i2c_target: code, strap and direction bits must fill one byte");
   end
   if (REG_W % DATA_W != 0 || REG_BYTES < 2) begin : g_bad_reg
      $error("tri_id_i2c_target: REG_W must be a multiple of DATA_W, at least two bytes");
   end
   if (PTR_W > DATA_W) begin : g_bad_ptr
      $error("tri_id_i2c_target: pointer must fit in one byte");
   end

   // ---------------- line conditioning ----------------
   logic [1:0] raw_lines, lvl, rise, fall;
   assign raw_lines = {sda_i, scl_i};

   for (genvar gi = 0; gi < 2; gi++) begin : g_line
      i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (raw_lines[gi]),
         .level_o (lvl[gi]),
         .rise_o  (rise[gi]),
         .fall_o  (fall[gi])
      );
   end

   logic scl_rise, scl_fall_evt, sda_lvl, start_evt, stop_evt;
   assign scl_rise     = rise[0];
   assign scl_fall_evt = fall[0];
   assign sda_lvl      = lvl[1];
   assign start_evt    = lvl[0] & ~rise[0] & fall[1];
   assign stop_evt     = lvl[0] & ~rise[0] & rise[1];

   // ---------------- state ----------------
   st_e               state;
   tgt_e              tgt_q;
   logic [BIT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [REG_W-1:0]  reg_buf;
   logic [RB_W-1:0]   rb_idx;
   logic [PTR_W-1:0]  ptr_q;
   logic              rw_q, first_q, ptr_pending, master_ack;
   logic              mem_wr_q, mem_first_q, mem_rd_q, prot_wr_q, prot_rd_q, reg_wr_q, reg_rd_q;
   logic [DATA_W-1:0] byte_wdata_q;
   logic [REG_W-1:0]  reg_wdata_q;

   // ---------------- address decode ----------------
   logic dec_hit;
   tgt_e dec_tgt;

   i2c_addr_match #(
      .CODE_W(CODE_W), .STRAP_W(STRAP_W),
      .CODE_MEM(CODE_MEM), .CODE_PROT(CODE_PROT), .CODE_SENS(CODE_SENS)
   ) u_match (
      .addr_i  (shreg[DATA_W-1:1]),
      .strap_i (strap_i),
      .hit_o   (dec_hit),
      .tgt_o   (dec_tgt)
   );

   // ---------------- read request and load ----------------
   logic              quiet_bus, addr_done, rd_req, load_go;
   tgt_e              rd_tgt;
   logic [REG_W-1:0]  reg_src;
   logic [DATA_W-1:0] tx_byte;

   assign quiet_bus = ~start_evt & ~stop_evt;
   assign addr_done = (state == ST_ADDR) && scl_fall_evt && (bit_cnt == BIT_LAST);
   assign rd_tgt    = (state == ST_ADDR) ? dec_tgt : tgt_q;

   always_comb begin
      rd_req = 1'b0;
      if (quiet_bus) begin
         if (addr_done && dec_hit && shreg[0])
            rd_req = 1'b1;
         else if (state == ST_RD_ACK && scl_rise && !sda_lvl)
            rd_req = (tgt_q != TGT_SENS) || (rb_idx == '0);
      end
   end

   assign load_go = quiet_bus && scl_fall_evt &&
                    ((state == ST_ADDR_ACK && rw_q) || (state == ST_RD_ACK && master_ack));

   assign reg_src = (rb_idx == '0) ? reg_rdata_i : reg_buf;

   always_comb begin
      case (tgt_q)
         TGT_MEM:  tx_byte = mem_rdata_i;
         TGT_PROT: tx_byte = prot_rdata_i;
         TGT_SENS: tx_byte = reg_src[REG_W-1 -: DATA_W];
         default:  tx_byte = '1;
      endcase
   end

   // ---------------- protocol engine ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         tgt_q        <= TGT_NONE;
         bit_cnt      <= '0;
         shreg        <= '0;
         reg_buf      <= '0;
         rb_idx       <= '0;
         ptr_q        <= '0;
         rw_q         <= 1'b0;
         first_q      <= 1'b0;
         ptr_pending  <= 1'b0;
         master_ack   <= 1'b0;
         mem_wr_q     <= 1'b0;
         mem_first_q  <= 1'b0;
         mem_rd_q     <= 1'b0;
         prot_wr_q    <= 1'b0;
         prot_rd_q    <= 1'b0;
         reg_wr_q     <= 1'b0;
         reg_rd_q     <= 1'b0;
         byte_wdata_q <= '0;
         reg_wdata_q  <= '0;
      end else begin
         mem_wr_q  <= 1'b0;
         prot_wr_q <= 1'b0;
         reg_wr_q  <= 1'b0;
         mem_rd_q  <= rd_req && (rd_tgt == TGT_MEM);
         prot_rd_q <= rd_req && (rd_tgt == TGT_PROT);
         reg_rd_q  <= rd_req && (rd_tgt == TGT_SENS);

         if (start_evt) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
         end else if (stop_evt) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[DATA_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (addr_done) begin
                     if (dec_hit) begin
                        state       <= ST_ADDR_ACK;
                        tgt_q       <= dec_tgt;
                        rw_q        <= shreg[0];
                        first_q     <= 1'b1;
                        ptr_pending <= ~shreg[0];
                        rb_idx      <= '0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall_evt) begin
                     bit_cnt <= '0;
                     state   <= rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                  end
               end
               ST_WR_BYTE: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[DATA_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall_evt && bit_cnt == BIT_LAST) begin
                     state <= ST_WR_ACK;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall_evt) begin
                     state   <= ST_WR_BYTE;
                     bit_cnt <= '0;
                     case (tgt_q)
                        TGT_MEM: begin
                           mem_wr_q     <= 1'b1;
                           mem_first_q  <= first_q;
                           byte_wdata_q <= shreg;
                           first_q      <= 1'b0;
                        end
                        TGT_PROT: begin
                           prot_wr_q    <= 1'b1;
                           byte_wdata_q <= shreg;
                        end
                        TGT_SENS: begin
                           if (ptr_pending) begin
                              ptr_q       <= shreg[PTR_W-1:0];
                              ptr_pending <= 1'b0;
                              rb_idx      <= '0;
                           end else if (rb_idx == RB_LAST) begin
                              reg_wr_q    <= 1'b1;
                              reg_wdata_q <= {reg_buf[REG_W-DATA_W-1:0], shreg};
                              rb_idx      <= '0;
                           end else begin
                              reg_buf <= {reg_buf[REG_W-DATA_W-1:0], shreg};
                              rb_idx  <= rb_idx + RB_W'(1);
                           end
                        end
                        default: ;
                     endcase
                  end
               end
               ST_RD_BYTE: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall_evt) begin
                     if (bit_cnt == BIT_LAST) state <= ST_RD_ACK;
                     else                     shreg <= {shreg[DATA_W-2:0], 1'b0};
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     master_ack <= ~sda_lvl;
                  end else if (scl_fall_evt) begin
                     bit_cnt <= '0;
                     state   <= master_ack ? ST_RD_BYTE : ST_IDLE;
                  end
               end
               default: ;
            endcase
         end

         if (load_go) begin
            shreg   <= tx_byte;
            reg_buf <= reg_src << DATA_W;
            rb_idx  <= (rb_idx == RB_LAST) ? '0 : rb_idx + RB_W'(1);
         end
      end
   end

   assign sda_oe_o     = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                         (state == ST_RD_BYTE && !shreg[DATA_W-1]);
   assign byte_wdata_o = byte_wdata_q;
   assign mem_wr_o     = mem_wr_q;
   assign mem_first_o  = mem_first_q;
   assign mem_rd_o     = mem_rd_q;
   assign prot_wr_o    = prot_wr_q;
   assign prot_rd_o    = prot_rd_q;
   assign reg_ptr_o    = ptr_q;
   assign reg_wdata_o  = reg_wdata_q;
   assign reg_wr_o     = reg_wr_q;
   assign reg_rd_o     = reg_rd_q;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_oe,
   input logic start_evt,
   input logic stop_evt,
   input logic scl_fall_evt,
   input logic mem_wr,
   input logic mem_rd,
   input logic prot_wr,
   input logic prot_rd,
   input logic reg_wr,
   input logic reg_rd
);
   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_wr, mem_rd, prot_wr, prot_rd, reg_wr, reg_rd}));

   assert_reg_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !sda_oe);

   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   assert_mem_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(scl_fall_evt));

   assert_prot_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      prot_wr |-> $past(scl_fall_evt));

   assert_reg_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $past(scl_fall_evt));
endmodule

bind tri_id_i2c_target i2c_tgt_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sda_oe       (sda_oe_o),
   .start_evt    (start_evt),
   .stop_evt     (stop_evt),
   .scl_fall_evt (scl_fall_evt),
   .mem_wr       (mem_wr_o),
   .mem_rd       (mem_rd_o),
   .prot_wr      (prot_wr_o),
   .prot_rd      (prot_rd_o),
   .reg_wr       (reg_wr_o),
   .reg_rd       (reg_rd_o)
);

// File: tb/tri_id_i2c_target_bench.sv
module tri_id_i2c_target_bench;
   localparam int Q = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  strap = 3'b101;
   logic        sda_oe;
   logic [7:0]  byte_wdata, mem_rdata = 8'h00, prot_rdata = 8'h00;
   logic        mem_wr, mem_first, mem_rd, prot_wr, prot_rd, reg_wr, reg_rd;
   logic [7:0]  reg_ptr;
   logic [15:0] reg_wdata, reg_rdata = 16'h0000;
   wire         sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int fails  = 0;
   int quiet_viol = 0;
   bit quiet_mode = 1'b0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] model_regs[16];
   logic [15:0] back_regs[16];
   logic [7:0]  mem_cnt = 8'h21, prot_cnt = 8'hC4;
   logic [7:0]  exp_mem = 8'h21, exp_prot = 8'hC4;

   always #10 clk = ~clk;

   tri_id_i2c_target u_tri_id_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
      .sda_oe_o(sda_oe), .byte_wdata_o(byte_wdata),
      .mem_wr_o(mem_wr), .mem_first_o(mem_first), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
      .prot_wr_o(prot_wr), .prot_rd_o(prot_rd), .prot_rdata_i(prot_rdata),
      .reg_ptr_o(reg_ptr), .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
      .reg_rdata_i(reg_rdata)
   );

   task automatic check_eq(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ev(input int kind, input logic [23:0] d);
      return {kind[7:0], d};
   endfunction

   task automatic expect_ev(input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic got_ev(input logic [31:0] e);
      logic [31:0] x;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
         fails++;
         $display("FAIL R11 unexpected strobe: actual %0h expected none", e);
      end else begin
         x = exp_q.pop_front();
         t = tag_q.pop_front();
         if (x !== e) begin
            fails++;
            $display("FAIL %s strobe: actual %0h expected %0h", t, e, x);
         end
      end
   endtask

   // back ends, responding half a cycle after each strobe
   always @(negedge clk) begin
      if (mem_rd) begin mem_rdata = mem_cnt; mem_cnt = mem_cnt + 8'h11; end
      if (prot_rd) begin prot_rdata = prot_cnt; prot_cnt = prot_cnt + 8'h03; end
      if (reg_wr) back_regs[reg_ptr[3:0]] = reg_wdata;
      if (reg_rd) reg_rdata = back_regs[reg_ptr[3:0]];
   end

   // per-clock comparison against the expected strobe list
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (($countones({mem_wr, mem_rd, prot_wr, prot_rd, reg_wr, reg_rd})) > 1) begin
            checks++; fails++;
            $display("FAIL R11 simultaneous strobes: actual %0b expected at most one",
                     {mem_wr, mem_rd, prot_wr, prot_rd, reg_wr, reg_rd});
         end
         if (mem_wr)  got_ev(ev(1, {15'd0, mem_first, byte_wdata}));
         if (mem_rd)  got_ev(ev(2, 24'd0));
         if (prot_wr) got_ev(ev(3, {16'd0, byte_wdata}));
         if (prot_rd) got_ev(ev(4, 24'd0));
         if (reg_wr)  got_ev(ev(5, {reg_ptr, reg_wdata}));
         if (reg_rd)  got_ev(ev(6, {16'd0, reg_ptr}));
         if (quiet_mode && sda_oe) quiet_viol++;
      end
   end

   task automatic wq;
      repeat (Q) @(negedge clk);
   endtask

   task automatic send_start;
      sda_m = 1'b1; wq; scl = 1'b1; wq; sda_m = 1'b0; wq; scl = 1'b0; wq;
   endtask

   task automatic send_stop;
      sda_m = 1'b0; wq; scl = 1'b1; wq; sda_m = 1'b1; wq;
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq; scl = 1'b1; wq; b = sda_line; wq; scl = 1'b0; wq;
   endtask

   task automatic put_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic get_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
      put_bit(~ack);
   endtask

   function automatic logic [7:0] addr(input logic [3:0] code, input logic [2:0] s, input logic rd);
      return {code, s, rd};
   endfunction

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] d;
      for (int i = 0; i < 16; i++) begin
         model_regs[i] = 16'h6000 + 16'(i) * 16'h0101;
         back_regs[i]  = model_regs[i];
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: reset state
      check_eq("R1", "sda_oe after reset", sda_oe, 0);
      check_eq("R11", "strobes after reset", {mem_wr, mem_rd, prot_wr, prot_rd, reg_wr, reg_rd}, 0);

      // R5: memory write, three bytes
      expect_ev(ev(1, {15'd0, 1'b1, 8'h3C}), "R5");
      expect_ev(ev(1, {15'd0, 1'b0, 8'h5A}), "R5");
      expect_ev(ev(1, {15'd0, 1'b0, 8'hC3}), "R5");
      send_start;
      put_byte(addr(4'b1010, strap, 1'b0), ack); check_eq("R2", "mem write address ack", ack, 1);
      put_byte(8'h3C, ack); check_eq("R4", "mem data ack", ack, 1);
      put_byte(8'h5A, ack); check_eq("R4", "mem data ack", ack, 1);
      put_byte(8'hC3, ack); check_eq("R4", "mem data ack", ack, 1);
      send_stop;
      check_eq("R1", "sda released after stop", sda_oe, 0);

      // R6: memory read, three bytes, last NoAck
      for (int k = 0; k < 3; k++) expect_ev(ev(2, 24'd0), "R6");
      send_start;
      put_byte(addr(4'b1010, strap, 1'b1), ack); check_eq("R2", "mem read address ack", ack, 1);
      for (int k = 0; k < 3; k++) begin
         get_byte(d, k < 2);
         check_eq("R6", "mem read byte", d, exp_mem);
         exp_mem = exp_mem + 8'h11;
      end
      send_stop;

      // R7: protection write then read
      expect_ev(ev(3, {16'd0, 8'h00}), "R7");
      expect_ev(ev(3, {16'd0, 8'h81}), "R7");
      send_start;
      put_byte(addr(4'b0110, strap, 1'b0), ack); check_eq("R2", "prot write address ack", ack, 1);
      put_byte(8'h00, ack); check_eq("R7", "prot data ack", ack, 1);
      put_byte(8'h81, ack); check_eq("R7", "prot data ack", ack, 1);
      send_stop;
      expect_ev(ev(4, 24'd0), "R7");
      send_start;
      put_byte(addr(4'b0110, strap, 1'b1), ack); check_eq("R2", "prot read address ack", ack, 1);
      get_byte(d, 1'b0); check_eq("R7", "prot read byte", d, exp_prot);
      send_stop;

      // R3: strap mismatch, then unknown code; nothing driven, no strobe
      quiet_mode = 1'b1;
      send_start;
      put_byte(addr(4'b1010, 3'b001, 1'b0), ack); check_eq("R3", "strap mismatch ack", ack, 0);
      put_byte(8'h00, ack); check_eq("R3", "ignored data ack", ack, 0);
      send_stop;
      send_start;
      put_byte(addr(4'b1111, strap, 1'b1), ack); check_eq("R3", "unknown code ack", ack, 0);
      get_byte(d, 1'b0); check_eq("R3", "ignored read line", d, 8'hFF);
      send_stop;
      quiet_mode = 1'b0;
      check_eq("R3", "cycles driven while unmatched", quiet_viol, 0);

      // R8: new strap value, pointer 5 then one word
      strap = 3'b010;
      repeat (4) @(negedge clk);
      expect_ev(ev(5, {8'h05, 16'hBEEF}), "R8");
      send_start;
      put_byte(addr(4'b0011, strap, 1'b0), ack); check_eq("R2", "sensor write address ack", ack, 1);
      put_byte(8'h05, ack); check_eq("R8", "pointer ack", ack, 1);
      put_byte(8'hBE, ack); check_eq("R8", "high byte ack", ack, 1);
      put_byte(8'hEF, ack); check_eq("R8", "low byte ack", ack, 1);
      send_stop;
      model_regs[5] = 16'hBEEF;

      // R10: pointer write, repeated START, two-byte read
      expect_ev(ev(6, {16'd0, 8'h05}), "R10");
      send_start;
      put_byte(addr(4'b0011, strap, 1'b0), ack);
      put_byte(8'h05, ack);
      send_start;
      put_byte(addr(4'b0011, strap, 1'b1), ack); check_eq("R10", "read address after repeated start", ack, 1);
      get_byte(d, 1'b1); check_eq("R10", "register high byte", d, model_regs[5][15:8]);
      get_byte(d, 1'b0); check_eq("R10", "register low byte", d, model_regs[5][7:0]);
      send_stop;

      // R9: pointer 6, one byte only, STOP; then read keeps pointer 6
      send_start;
      put_byte(addr(4'b0011, strap, 1'b0), ack);
      put_byte(8'h06, ack);
      put_byte(8'h12, ack);
      send_stop;
      expect_ev(ev(6, {16'd0, 8'h06}), "R9");
      send_start;
      put_byte(addr(4'b0011, strap, 1'b1), ack);
      get_byte(d, 1'b1); check_eq("R9", "untouched high byte", d, model_regs[6][15:8]);
      get_byte(d, 1'b0); check_eq("R9", "untouched low byte", d, model_regs[6][7:0]);
      send_stop;

      // R8: block write of two words to pointer 2, then four-byte read
      expect_ev(ev(5, {8'h02, 16'h1122}), "R8");
      expect_ev(ev(5, {8'h02, 16'h3344}), "R8");
      send_start;
      put_byte(addr(4'b0011, strap, 1'b0), ack);
      put_byte(8'h02, ack);
      put_byte(8'h11, ack); put_byte(8'h22, ack);
      put_byte(8'h33, ack); put_byte(8'h44, ack);
      check_eq("R8", "second word low byte ack", ack, 1);
      send_stop;
      model_regs[2] = 16'h3344;
      expect_ev(ev(6, {16'd0, 8'h02}), "R10");
      expect_ev(ev(6, {16'd0, 8'h02}), "R10");
      send_start;
      put_byte(addr(4'b0011, strap, 1'b1), ack);
      for (int k = 0; k < 4; k++) begin
         get_byte(d, k < 3);
         check_eq("R10", "block read byte", d, (k % 2 == 0) ? model_regs[2][15:8] : model_regs[2][7:0]);
      end
      send_stop;

      repeat (20) @(negedge clk);
      check_eq("R11", "expected strobes left over", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule